// File: doc/BRIEF.md
# DDR SDRAM Mode-Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface and carries out the full command sequence that loads the memory's mode registers. A caller presents the requested burst length code, burst ordering, read latency code and a DLL-reset flag, tells the block whether every bank is already precharged, and pulses a start strobe. The block then owns the command bus until the programming is complete.

The block first checks the requested codes. Any reserved value is refused with a one-cycle error pulse, and no command reaches the memory. For a legal request, the block closes all banks with a precharge-all command if they are not already idle, and then waits out the precharge time. It writes the extended register first and the base register after it. Each of these writes is followed by the mode-register cycle time, filled with NOPs. A one-cycle done pulse marks the point at which the memory will accept any command again.

Top module: `mrs_seq`

## Requirements
- R1: After reset the command bus rests at NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and busy, done and err are low.
- R2: A burst-length code other than 001, 010 or 011 makes err high for exactly the one cycle after the start edge, and every cycle stays NOP.
- R3: A latency code other than 011 or 100 is rejected in the same way as R2: a one-cycle err pulse and no command.
- R4: If banks_idle is low when start is taken, the cycle after the start edge carries a precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr[10]=1.
- R5: After a precharge-all, the extended-register write appears exactly TRP cycles later, with NOPs in between.
- R6: If banks_idle is high when start is taken, no precharge is issued, and the extended-register write appears in the cycle after the start edge.
- R7: A register write drives all four command lines low. The extended write carries ba=01 and addr=EXT_WORD. The base write carries ba=00 and follows the extended write exactly TMRD cycles later.
- R8: The base write's address holds the burst-length code in bits 2:0, the ordering in bit 3 (1 = interleaved), the latency code in bits 6:4 and the DLL-reset flag in bit 8. Bit 7 and bits 11:9 are 0.
- R9: done is high for exactly one cycle, TMRD cycles after the base write. Every cycle of a sequence other than the issue cycles is NOP.
- R10: Request fields, banks_idle and start are sampled only while busy is low. Changes to them during a sequence have no effect on the commands issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| banks_idle | input | 1 | High when every bank is already precharged |
| bl_code | input | 3 | Requested burst-length code |
| bt_ilv | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cl_code | input | 3 | Requested read-latency code |
| dll_reset | input | 1 | Value for the DLL-reset bit |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| busy | output | 1 | High while a request is being handled |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench applies the next start strobe while the block is still busy, in the cycle right after the one in which it was taken. In that same cycle it scrambles every request field and the bank-idle flag. The block therefore has to issue its first command and ignore a fresh request in the same cycle. The bench judges this from the address words that appear later on the bus, which must match the first request only, and from the timing of every command, which must not restart. The sweep covers every code combination with both bank states, so this collision is met on the precharge path, on the direct-write path and on the refusal path.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int ADDR_W   = 12;
    localparam int BANK_W   = 2;
    localparam int AP_BIT   = 10;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_MRS  = 2'd2
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_ERR   = 4'd1,
        ST_PRE   = 4'd2,
        ST_RP    = 4'd3,
        ST_EXT   = 4'd4,
        ST_GAP_E = 4'd5,
        ST_BASE  = 4'd6,
        ST_GAP_B = 4'd7,
        ST_DONE  = 4'd8
    } state_e;

    typedef struct packed {
        logic [2:0] bl;
        logic       bt;
        logic [2:0] cl;
        logic       dll;
    } req_t;

    typedef struct packed {
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    localparam logic [BANK_W-1:0] BA_BASE = 2'b00;
    localparam logic [BANK_W-1:0] BA_EXT  = 2'b01;

    function automatic logic bl_legal(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic cl_legal(input logic [2:0] code);
        return (code == 3'b011) || (code == 3'b100);
    endfunction

    function automatic logic [ADDR_W-1:0] base_word(input req_t r);
        logic [ADDR_W-1:0] w;
        w      = '0;
        w[2:0] = r.bl;
        w[3]   = r.bt;
        w[6:4] = r.cl;
        w[8]   = r.dll;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] prea_word();
        logic [ADDR_W-1:0] w;
        w         = '0;
        w[AP_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/mrs_field_check.sv
module mrs_field_check
    import mrs_pkg::*;
(
    input  req_t req,
    output logic legal
);
    logic bl_ok;
    logic cl_ok;

    always_comb begin
        bl_ok = bl_legal(req.bl);
        cl_ok = cl_legal(req.cl);
        legal = bl_ok && cl_ok;
    end
endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/mrs_bus_drive.sv
module mrs_bus_drive
    import mrs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_WORD = '0
) (
    input  cmd_e cmd,
    input  logic sel_ext,
    input  req_t req,
    output bus_t bus
);
    always_comb begin
        bus       = '0;
        bus.cs_n  = 1'b0;
        bus.ras_n = 1'b1;
        bus.cas_n = 1'b1;
        bus.we_n  = 1'b1;
        unique case (cmd)
            CMD_PREA: begin
                bus.ras_n = 1'b0;
                bus.we_n  = 1'b0;
                bus.ba    = '0;
                bus.addr  = prea_word();
            end
            CMD_MRS: begin
                bus.ras_n = 1'b0;
                bus.cas_n = 1'b0;
                bus.we_n  = 1'b0;
                if (sel_ext) begin
                    bus.ba   = BA_EXT;
                    bus.addr = EXT_WORD;
                end else begin
                    bus.ba   = BA_BASE;
                    bus.addr = base_word(req);
                end
            end
            default: begin
                bus.ba   = '0;
                bus.addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
    import mrs_pkg::*;
#(
    parameter int                TRP      = 3,
    parameter int                TMRD     = 2,
    parameter logic [ADDR_W-1:0] EXT_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              banks_idle,
    input  logic [2:0]        bl_code,
    input  logic              bt_ilv,
    input  logic [2:0]        cl_code,
    input  logic              dll_reset,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int RP_GAP  = (TRP  > 2) ? TRP  - 1 : 1;
    localparam int MRD_GAP = (TMRD > 2) ? TMRD - 1 : 1;
    localparam int MAX_GAP = (RP_GAP > MRD_GAP) ? RP_GAP : MRD_GAP;
    localparam int CW      = (MAX_GAP > 1) ? $clog2(MAX_GAP) : 1;
    localparam logic [CW-1:0] RP_LOAD  = CW'(RP_GAP - 1);
    localparam logic [CW-1:0] MRD_LOAD = CW'(MRD_GAP - 1);

    state_e        state, state_nx;
    req_t          req_q, req_in;
    logic          legal_in;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;
    cmd_e          cmd;
    logic          sel_ext;
    bus_t          bus;

    assign req_in = '{bl: bl_code, bt: bt_ilv, cl: cl_code, dll: dll_reset};

    mrs_field_check u_check (
        .req   (req_in),
        .legal (legal_in)
    );

    mrs_gap_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!legal_in)       state_nx = ST_ERR;
                    else if (banks_idle) state_nx = ST_EXT;
                    else                 state_nx = ST_PRE;
                end
            end
            ST_ERR:  state_nx = ST_IDLE;
            ST_PRE: begin
                t_load   = 1'b1;
                t_val    = RP_LOAD;
                state_nx = ST_RP;
            end
            ST_RP:   if (t_zero) state_nx = ST_EXT;
            ST_EXT: begin
                t_load   = 1'b1;
                t_val    = MRD_LOAD;
                state_nx = ST_GAP_E;
            end
            ST_GAP_E: if (t_zero) state_nx = ST_BASE;
            ST_BASE: begin
                t_load   = 1'b1;
                t_val    = MRD_LOAD;
                state_nx = ST_GAP_B;
            end
            ST_GAP_B: if (t_zero) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                req_q <= req_in;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_PRE:          cmd = CMD_PREA;
            ST_EXT, ST_BASE: cmd = CMD_MRS;
            default:         cmd = CMD_NOP;
        endcase
        sel_ext = (state == ST_EXT);
    end

    mrs_bus_drive #(.EXT_WORD(EXT_WORD)) u_drive (
        .cmd     (cmd),
        .sel_ext (sel_ext),
        .req     (req_q),
        .bus     (bus)
    );

    assign cs_n  = bus.cs_n;
    assign ras_n = bus.ras_n;
    assign cas_n = bus.cas_n;
    assign we_n  = bus.we_n;
    assign ba    = bus.ba;
    assign addr  = bus.addr;
    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign err   = (state == ST_ERR);
endmodule

// File: rtl/mrs_seq_checker.sv
module mrs_seq_checker
    import mrs_pkg::*;
#(
    parameter int TRP  = 3,
    parameter int TMRD = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic              err
);
    logic       is_mrs, is_pre, is_nop;
    logic [15:0] gap;
    cmd_e       last;
    logic       ext_seen;

    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= 16'hFFFF;
            last     <= CMD_NOP;
            ext_seen <= 1'b0;
        end else begin
            if (is_mrs || is_pre) begin
                gap  <= 16'd1;
                last <= is_mrs ? CMD_MRS : CMD_PREA;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 16'd1;
            end
            if (is_mrs && ba == BA_EXT) ext_seen <= 1'b1;
            else if (done)              ext_seen <= 1'b0;
        end
    end

    p_rp_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && last == CMD_PREA) |-> (gap >= 16'(TRP)));

    p_mrd_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ((is_mrs || is_pre) && last == CMD_MRS) |-> (gap >= 16'(TMRD)));

    p_ext_first_r7: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && ba == BA_BASE) |-> ext_seen);

    p_fields_r8: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && ba == BA_BASE) |-> (!addr[7] && addr[11:9] == 3'b000));

    p_no_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && ba == BA_BASE) |-> (bl_legal(addr[2:0]) && cl_legal(addr[6:4])));

    p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        err |-> is_nop);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_prea_a10_r4: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> addr[AP_BIT]);
endmodule

bind mrs_seq mrs_seq_checker #(.TRP(TRP), .TMRD(TMRD)) u_mrs_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .done  (done),
    .err   (err)
);

// File: tb/test_mrs_seq.sv
`timescale 1ns/1ps
module test_mrs_seq;
    localparam int          TRP  = 3;
    localparam int          TMRD = 2;
    localparam logic [11:0] EXTW = 12'h000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        banks_idle = 1'b1;
    logic [2:0]  bl_code = '0;
    logic        bt_ilv = 1'b0;
    logic [2:0]  cl_code = '0;
    logic        dll_reset = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mrs_seq #(.TRP(TRP), .TMRD(TMRD), .EXT_WORD(EXTW)) i_mrs_seq (
        .clk(clk), .rst(rst), .start(start), .banks_idle(banks_idle),
        .bl_code(bl_code), .bt_ilv(bt_ilv), .cl_code(cl_code),
        .dll_reset(dll_reset), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] cmd_now();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic run(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                       input logic dl, input logic idle);
        logic        valid;
        int          p, e, m, d, last;
        logic [11:0] word;
        logic [3:0]  exp_cmd;
        valid = (bl >= 3'd1 && bl <= 3'd3) && (cl == 3'd3 || cl == 3'd4);
        p = idle ? -1 : 1;
        e = idle ? 1 : 1 + TRP;
        m = e + TMRD;
        d = m + TMRD;
        last = valid ? d + 1 : 2;
        word = 12'(bl) | (12'(bt) << 3) | (12'(cl) << 4) | (12'(dl) << 8);
        @(negedge clk);
        bl_code = bl; bt_ilv = bt; cl_code = cl; dll_reset = dl;
        banks_idle = idle; start = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            exp_cmd = 4'b0111;
            if (valid && k == p)              exp_cmd = 4'b0010;
            if (valid && (k == e || k == m))  exp_cmd = 4'b0000;
            if (valid && k == p)
                check("R4", cmd_now(), exp_cmd);
            else if (valid && k == e)
                check(idle ? "R6" : "R5", cmd_now(), exp_cmd);
            else if (valid && k == m)
                check("R7", cmd_now(), exp_cmd);
            else if (!valid)
                check(bl_legal_tb(bl) ? "R3" : "R2", cmd_now(), exp_cmd);
            else
                check("R9", cmd_now(), exp_cmd);
            if (valid && k == p) check("R4", 32'(addr[10]), 32'd1);
            if (valid && k == e) check("R7", {18'd0, ba, addr}, {18'd0, 2'b01, EXTW});
            if (valid && k == m) check("R8 R10", {18'd0, ba, addr}, {18'd0, 2'b00, word});
            check("R9", 32'(done), 32'(valid && k == d));
            if (!valid) check(bl_legal_tb(bl) ? "R3" : "R2", 32'(err), 32'(k == 1));
            else        check("R2", 32'(err), 32'd0);
            check("R10", 32'(busy), valid ? 32'(k <= d) : 32'(k == 1));
            if (k == 1) begin
                bl_code = ~bl; bt_ilv = ~bt; cl_code = cl ^ 3'b111;
                dll_reset = ~dl; banks_idle = ~idle;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    function automatic logic bl_legal_tb(input logic [2:0] c);
        return c >= 3'd1 && c <= 3'd3;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 32'(cmd_now()), 32'h7);
        check("R1", {29'd0, busy, done, err}, 32'd0);
        for (int bl = 0; bl < 8; bl++)
            for (int cl = 0; cl < 8; cl++)
                for (int v = 0; v < 8; v++)
                    run(3'(bl), v[0], 3'(cl), v[1], v[2]);
        @(negedge clk);
        check("R1", 32'(cmd_now()), 32'h7);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule